// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Controller

This block runs read cycles on an external asynchronous parallel ROM from a synchronous host. The ROM can present its contents as 16-bit words or as 8-bit bytes. The host gives an address, a flag that picks byte or word access, and a one-cycle request. The controller then drives the ROM address lines, chip enable, output enable and the organisation select. It counts the access times in system clock cycles, captures the data and returns it with a one-cycle valid pulse. After that it waits out the output turn-off time before it takes the next request.

In byte mode the ROM pin that carries data bit 15 in word mode becomes an address input. It supplies the least significant byte address bit. The controller drives that pin only in byte mode and discards the upper data lines, which the ROM leaves floating. The access time, the output-enable access time and the turn-off time are parameters in clock cycles, rounded up from the ROM's nanosecond figures.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, `ready_o`=1, `rom_ce_n_o`=1, `rom_oe_n_o`=1 and `rvalid_o`=0.
- R2: A word request (`mode_byte_i`=0) drives `rom_wide_o`=1 and `rom_addr_o`=`haddr_i[21:0]`, leaves `rom_top_oe_o`=0, and returns all 16 bits of `rom_d_i` on `rdata_o`.
- R3: A byte request (`mode_byte_i`=1) drives `rom_wide_o`=0, `rom_addr_o`=`haddr_i[22:1]`, `rom_top_o`=`haddr_i[0]` and `rom_top_oe_o`=1. It returns `{8'h00, rom_d_i[7:0]}`, so `rom_d_i[15:8]` has no effect. The top pin is never driven while the ROM is in word mode with both enables low.
- R4: `rvalid_o` is a single-cycle pulse. It rises exactly T_ACC cycles after the clock edge that accepts the request, and never before chip enable has been low for T_ACC cycles.
- R5: Output enable is low only while chip enable is low. It falls exactly T_ACC−T_OE cycles after the accept edge.
- R6: While chip enable stays low, `rom_addr_o`, `rom_top_o` and `rom_wide_o` do not change.
- R7: In the cycle after the valid pulse, both enables go high. `ready_o` then returns exactly T_DF+1 cycles after the valid pulse.
- R8: A request made while `ready_o` is low is dropped. It produces no read and no valid pulse.
- R9: Whenever `ready_o` is high, the ROM is in standby: both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| req_i | input | 1 | Read request, taken only while ready |
| mode_byte_i | input | 1 | 1 = byte access, 0 = word access |
| haddr_i | input | 23 | Byte address (byte mode) or word address in bits 21:0 (word mode) |
| ready_o | output | 1 | Controller idle and able to take a request |
| rvalid_o | output | 1 | One-cycle pulse marking `rdata_o` valid |
| rdata_o | output | 16 | Read result, zero-extended in byte mode |
| rom_addr_o | output | 22 | ROM address lines |
| rom_ce_n_o | output | 1 | ROM chip enable, active low |
| rom_oe_n_o | output | 1 | ROM output enable, active low |
| rom_wide_o | output | 1 | ROM organisation select, 1 = word, 0 = byte |
| rom_top_o | output | 1 | Value driven on the dual-use top pin (byte LSB) |
| rom_top_oe_o | output | 1 | Drive enable for the top pin |
| rom_d_i | input | 16 | ROM data lines; bit 15 is the input side of the top pin |

## Verification
The bench models the ROM so that it returns a corrupt value unless chip enable, output enable and every address pin have each been stable for their full cycle budgets. Any internal state that ends a wait early, moves an address bit mid-cycle or mixes up the modes therefore shows up as wrong `rdata_o` on that same read's valid pulse. A countdown that is off by one appears as a valid pulse, an output-enable fall or a return of `ready_o` that lands one cycle away from its expected cycle. A mode flag latched wrongly shows up at once in the next cycle as a wrong organisation select or a wrong top-pin drive enable.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_CAPT = 2'd3
    } rd_state_e;

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rom_rd_pins.sv
module rom_rd_pins #(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic          byte_mode_i,
    input  logic [AW:0]   haddr_i,
    input  logic [DW-1:0] rom_d_i,
    output logic [AW-1:0] rom_addr_o,
    output logic          top_o,
    output logic          top_oe_o,
    output logic          wide_o,
    output logic [DW-1:0] rdata_o
);
    localparam int BW = DW / 2;

    always_comb begin
        if (byte_mode_i) begin
            rom_addr_o = haddr_i[AW:1];
            top_o      = haddr_i[0];
            top_oe_o   = 1'b1;
            wide_o     = 1'b0;
            rdata_o    = {{(DW-BW){1'b0}}, rom_d_i[BW-1:0]};
        end else begin
            rom_addr_o = haddr_i[AW-1:0];
            top_o      = 1'b0;
            top_oe_o   = 1'b0;
            wide_o     = 1'b1;
            rdata_o    = rom_d_i;
        end
    end

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int AW    = 22,
    parameter int DW    = 16,
    parameter int T_ACC = 15,
    parameter int T_OE  = 7,
    parameter int T_DF  = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic          mode_byte_i,
    input  logic [AW:0]   haddr_i,
    output logic          ready_o,
    output logic          rvalid_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] rom_addr_o,
    output logic          rom_ce_n_o,
    output logic          rom_oe_n_o,
    output logic          rom_wide_o,
    output logic          rom_top_o,
    output logic          rom_top_oe_o,
    input  logic [DW-1:0] rom_d_i
);
    localparam int TMAX = (T_ACC > T_DF) ? T_ACC : T_DF;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int AGW  = CW + 1;
    localparam logic [CW-1:0] ACC_C = CW'(T_ACC);
    localparam logic [CW-1:0] DF_C  = CW'(T_DF);
    localparam logic [CW-1:0] OE_C  = CW'((T_OE < TMAX) ? T_OE : TMAX);
    localparam logic          OE_LATE = (T_ACC > T_OE);

    typedef struct packed {
        rd_state_e     st;
        logic [AW:0]   haddr;
        logic          byte_m;
        logic          ce_n;
        logic          oe_n;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic          t_load;
    logic [CW-1:0] t_val;
    logic [CW-1:0] t_cnt;
    logic          t_zero;
    logic [CW-1:0] t_next;
    logic [DW-1:0] pin_rdata;

    rom_rd_timer #(.CW(CW)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (t_load),
        .val_i  (t_val),
        .cnt_o  (t_cnt),
        .zero_o (t_zero)
    );

    rom_rd_pins #(.AW(AW), .DW(DW)) u_pins (
        .byte_mode_i (r_q.byte_m),
        .haddr_i     (r_q.haddr),
        .rom_d_i     (rom_d_i),
        .rom_addr_o  (rom_addr_o),
        .top_o       (rom_top_o),
        .top_oe_o    (rom_top_oe_o),
        .wide_o      (rom_wide_o),
        .rdata_o     (pin_rdata)
    );

    assign t_next = t_cnt - 1'b1;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        t_load     = 1'b0;
        t_val      = ACC_C;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i && t_zero) begin
                    r_d.st     = ST_ADDR;
                    r_d.haddr  = haddr_i;
                    r_d.byte_m = mode_byte_i;
                    r_d.ce_n   = 1'b0;
                    r_d.oe_n   = OE_LATE;
                    t_load     = 1'b1;
                    t_val      = ACC_C;
                end
            end
            ST_ADDR: begin
                r_d.st   = ST_WAIT;
                r_d.oe_n = (t_next > OE_C);
            end
            ST_WAIT: begin
                r_d.oe_n = (t_next > OE_C);
                if (t_cnt == CW'(1)) begin
                    r_d.st     = ST_CAPT;
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = pin_rdata;
                end
            end
            ST_CAPT: begin
                r_d.st   = ST_IDLE;
                r_d.ce_n = 1'b1;
                r_d.oe_n = 1'b1;
                t_load   = 1'b1;
                t_val    = DF_C;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.ce_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o    = (r_q.st == ST_IDLE) && t_zero;
    assign rvalid_o   = r_q.rvalid;
    assign rdata_o    = r_q.rdata;
    assign rom_ce_n_o = r_q.ce_n;
    assign rom_oe_n_o = r_q.oe_n;

    // Cycle counters used only by the checks below
    logic [AGW-1:0] ce_low_q, ce_high_q;
    localparam logic [AGW-1:0] AG_MAX = '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ce_low_q  <= '0;
            ce_high_q <= AG_MAX;
        end else begin
            ce_low_q  <= rom_ce_n_o ? '0 : ((ce_low_q == AG_MAX) ? AG_MAX : ce_low_q + 1'b1);
            ce_high_q <= !rom_ce_n_o ? '0 : ((ce_high_q == AG_MAX) ? AG_MAX : ce_high_q + 1'b1);
        end
    end

    AST_CAPT_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> (ce_low_q >= AGW'(T_ACC))); // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |=> !rvalid_o); // R4
    AST_OE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rom_oe_n_o |-> !rom_ce_n_o); // R5
    AST_PINS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rom_ce_n_o && !$past(rom_ce_n_o)) |->
            ($stable(rom_addr_o) && $stable(rom_top_o) && $stable(rom_wide_o))); // R6
    AST_TURNOFF_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (ce_high_q >= AGW'(T_DF))); // R7
    AST_BUSY_REQ_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |=> !$fell(rom_ce_n_o)); // R8
    AST_READY_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (rom_ce_n_o && rom_oe_n_o)); // R9

endmodule

// File: tb/sim_rom_rd_ctrl.sv
module sim_rom_rd_ctrl;
    localparam int AW    = 22;
    localparam int DW    = 16;
    localparam int T_ACC = 15;
    localparam int T_OE  = 7;
    localparam int T_DF  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req = 1'b0;
    logic          mode_byte = 1'b0;
    logic [AW:0]   haddr = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] rom_addr;
    logic          ce_n, oe_n, wide, top, top_oe;
    logic [DW-1:0] rom_d;

    rom_rd_ctrl #(.AW(AW), .DW(DW), .T_ACC(T_ACC), .T_OE(T_OE), .T_DF(T_DF)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_byte_i(mode_byte),
        .haddr_i(haddr), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
        .rom_addr_o(rom_addr), .rom_ce_n_o(ce_n), .rom_oe_n_o(oe_n),
        .rom_wide_o(wide), .rom_top_o(top), .rom_top_oe_o(top_oe), .rom_d_i(rom_d)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] wordpat(input logic [AW-1:0] a);
        return {a[7:0] ^ a[21:14], a[15:8] ^ 8'hC3};
    endfunction

    function automatic logic [15:0] expect_val(input logic bm, input logic [AW:0] a);
        logic [15:0] w;
        if (!bm) return wordpat(a[AW-1:0]);
        w = wordpat(a[AW:1]);
        return {8'h00, (a[0] ? w[15:8] : w[7:0])};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    // Behavioural ROM: stale value unless every timing budget has elapsed
    int ce_age = 0, oe_age = 0, pin_age = 0;
    logic [AW+1:0] pin_prev = '0;
    logic [AW+1:0] pin_now;
    assign pin_now = {rom_addr, top, wide};

    always @(posedge clk) begin
        ce_age   <= ce_n ? 0 : ce_age + 1;
        oe_age   <= oe_n ? 0 : oe_age + 1;
        pin_age  <= (pin_now != pin_prev) ? 1 : pin_age + 1;
        pin_prev <= pin_now;
    end

    logic rom_ok;
    logic [15:0] rom_word;
    assign rom_ok = !ce_n && !oe_n && (ce_age + 1 >= T_ACC) &&
                    (pin_age + 1 >= T_ACC) && (oe_age + 1 >= T_OE);
    assign rom_word = wordpat(rom_addr);
    always_comb begin
        if (!rom_ok)   rom_d = 16'hDEAD;
        else if (wide) rom_d = rom_word;
        else           rom_d = {top, 7'h7F, (top ? rom_word[15:8] : rom_word[7:0])};
    end

    // Scoreboard
    typedef struct {
        logic [15:0] data;
        int          c_acc;
    } exp_t;
    exp_t sq[$];

    task automatic do_read(input logic bm, input logic [AW:0] a);
        exp_t e;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; mode_byte = bm; haddr = a;
        e.data = expect_val(bm, a);
        e.c_acc = cyc + 1;
        sq.push_back(e);
        @(negedge clk);
        req = 1'b0;
        if (bm) begin
            chk("R3 wide", {31'd0, wide}, 32'd0);
            chk("R3 addr", {10'd0, rom_addr}, {10'd0, a[AW:1]});
            chk("R3 top", {30'd0, top_oe, top}, {30'd0, 1'b1, a[0]});
        end else begin
            chk("R2 wide", {31'd0, wide}, 32'd1);
            chk("R2 addr", {10'd0, rom_addr}, {10'd0, a[AW-1:0]});
            chk("R2 top_oe", {31'd0, top_oe}, 32'd0);
        end
    endtask

    int oe_fall = 0, cap_cyc = 0;
    logic oe_prev = 1'b1, ce_prev = 1'b1, wait_rdy = 1'b0;
    logic [AW+1:0] pins_prev = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (!oe_n && oe_prev) oe_fall = cyc;
            if (!oe_n) chk("R5 oe under ce", {31'd0, ce_n}, 32'd0);
            if (ready) chk("R9 standby", {30'd0, ce_n, oe_n}, 32'd3);
            if (!ce_n && !oe_n && wide) chk("R3 no top drive in word mode", {31'd0, top_oe}, 32'd0);
            if (!ce_n && !ce_prev) chk("R6 pins held", {8'd0, pin_now}, {8'd0, pins_prev});
            if (rvalid) begin
                if (sq.size() == 0) begin
                    chk("R8 unexpected valid", 32'd1, 32'd0);
                end else begin
                    e = sq.pop_front();
                    chk("R2/R3 data", {16'd0, rdata}, {16'd0, e.data});
                    chk("R4 latency", cyc - e.c_acc, T_ACC);
                    chk("R5 oe fall", oe_fall - e.c_acc, T_ACC - T_OE);
                end
                cap_cyc = cyc;
                wait_rdy = 1'b1;
            end else if (wait_rdy) begin
                if (cyc == cap_cyc + 1) begin
                    chk("R4 single pulse", {31'd0, rvalid}, 32'd0);
                    chk("R7 enables off", {30'd0, ce_n, oe_n}, 32'd3);
                end
                if (ready) begin
                    chk("R7 turnoff", cyc - cap_cyc, T_DF + 1);
                    wait_rdy = 1'b0;
                end
            end
            oe_prev = oe_n;
            ce_prev = ce_n;
            pins_prev = pin_now;
        end
    end

    task automatic drain();
        int n = 0;
        while ((sq.size() != 0 || !ready || wait_rdy) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R4 drained", sq.size(), 0);
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", {31'd0, ready}, 32'd1);
        chk("R1 enables", {30'd0, ce_n, oe_n}, 32'd3);
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", {31'd0, ready}, 32'd1);

        do_read(1'b0, 23'h000000);
        do_read(1'b0, 23'h3FFFFF);
        do_read(1'b0, 23'h523456);
        do_read(1'b1, 23'h000000);
        do_read(1'b1, 23'h000001);
        do_read(1'b1, 23'h7FFFFF);
        do_read(1'b1, 23'h2AB5C3);
        do_read(1'b0, 23'h2AB5C3);
        drain();

        // R8: requests while busy are dropped
        do_read(1'b0, 23'h012345);
        repeat (4) @(negedge clk);
        req = 1'b1; mode_byte = 1'b1; haddr = 23'h7F0F0F;
        @(negedge clk);
        req = 1'b0;
        drain();
        repeat (T_ACC + 5) @(negedge clk);
        chk("R8 no extra read", {31'd0, ce_n}, 32'd1);

        for (int i = 0; i < 6; i++) begin
            do_read(i[0], 23'(i * 23'h13579B));
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule